// File: doc/BRIEF.md
# Dual-Port PS/2 Host Register Front End

This block is the register face of a two-channel PS/2 host controller. One channel serves a keyboard and the other a mouse. Each channel occupies its own 256-byte window on a simple synchronous byte-wide register bus, and each window holds an identity register, a receive-data register, a control register and a status register. Serial clocking, framing and parity belong to separate line engines, which are outside this block. On the device side, each channel issues a one-cycle transmit strobe with a byte and accepts received bytes into a 16-entry FIFO.

Each channel has a loopback mode. In that mode a transmitted byte is held locally and handed back as received data, and it raises the channel's interrupt. A diagnostic mode makes the line-shadow status bits follow the programmed line directions. The two channel interrupts are combined onto one output, and the combined state shows in the status register of either channel.

Top module: `ps2_dual_regif`

## Requirements
- R1: Bit 8 of the address selects the channel (0 keyboard, 1 mouse) and bits [3:2] select the register. The other address bits are ignored. Read data appears on `rdata_o` with `rvalid_o` high in the cycle after the request.
- R2: A read of register 0 returns 0x00 for the keyboard and 0x01 for the mouse.
- R3: A write to register 2 stores the control byte, and a read of register 2 returns it unchanged. Control bits: 0 enable, 1 loopback, 5 diagnostic, 6 data direction, 7 clock direction. A write to register 0 changes nothing, and reset clears control to 0x00.
- R4: With loopback off, a write to register 1 raises that channel's `tx_valid_o` bit in the same cycle, with the byte on its lane of `tx_data_o`.
- R5: With loopback on, a write to register 1 raises no transmit strobe. It stores the byte and sets the channel's loopback-full flag. A read of register 1 returns the stored byte and clears the flag.
- R6: Outside loopback, received bytes enter a 16-entry FIFO in arrival order and are dropped while it is full. A read of register 1 returns the oldest byte and removes it.
- R7: A read of register 1 with the FIFO empty and loopback off returns 0x00 and leaves the FIFO unchanged.
- R8: Status (register 3) layout: bit 0 receive-not-empty, bit 4 combined interrupt, bit 6 data shadow, bit 7 clock shadow. Bits 1, 2, 3 and 5 read 0.
- R9: Both shadow bits read 1 unless diagnostic is set. With diagnostic set, data shadow equals data direction and clock shadow equals clock direction.
- R10: A channel's interrupt flag is its loopback-full flag when loopback is on, and FIFO-not-empty otherwise. Receive-not-empty follows the same rule. `irq_o` is the OR of both flags and is reflected in status bit 4 of both channels.
- R11: A FIFO push and a data read in the same cycle both take effect. When full, the head is returned and the new byte is kept. When empty, 0x00 is returned and the new byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 9 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| tx_valid_o | output | 2 | Transmit strobe per channel (bit 0 keyboard) |
| tx_data_o | output | 16 | Transmit byte per channel (bits 7:0 keyboard) |
| rx_valid_i | input | 2 | Received byte strobe per channel |
| rx_data_i | input | 16 | Received byte per channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
The collision that matters is a device-side byte arriving in the same cycle as a bus read that pops the same channel's FIFO. The bench sets up that collision twice. The first time the FIFO is empty: the read must return 0x00 and the new byte must remain. The second time the FIFO holds 16 bytes: the read must return the head, and the late byte must come out after the 15 older survivors. The scoreboard judges each case from the complete sequence of bytes drained afterwards, including the final empty read.

// File: rtl/ps2_regif_pkg.sv
package ps2_regif_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    REG_ID   = 2'd0,
    REG_DATA = 2'd1,
    REG_CTRL = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  localparam int CTL_LOOP = 1;
  localparam int CTL_DIAG = 5;
  localparam int CTL_DDIR = 6;
  localparam int CTL_CDIR = 7;

  localparam int ST_RBNE = 0;
  localparam int ST_CMP  = 4;
  localparam int ST_DSHD = 6;
  localparam int ST_CSHD = 7;
endpackage

// File: rtl/ps2_rx_fifo.sv
module ps2_rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          full, pop_ok, push_ok;

  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign pop_ok  = pop_i && !empty_o;
  // a pop in the same cycle frees a slot for the incoming byte
  assign push_ok = push_i && (!full || pop_ok);
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/ps2_host_port.sv
module ps2_host_port
  import ps2_regif_pkg::*;
#(
  parameter int PORT_ID = 0,
  parameter int DEPTH   = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  reg_sel_e      sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          irq_any_i,
  output logic [DW-1:0] rdata_o,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  output logic          irq_o
);
  logic [DW-1:0] ctrl_q, lb_buf_q, fifo_head, status;
  logic          lb_full_q, fifo_empty, loop_on, data_wr, data_rd, rbne;

  assign loop_on = ctrl_q[CTL_LOOP];
  assign data_wr = wr_en_i && (sel_i == REG_DATA);
  assign data_rd = rd_en_i && (sel_i == REG_DATA);

  assign tx_valid_o = data_wr && !loop_on;
  assign tx_data_o  = wdata_i;

  ps2_rx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_valid_i),
    .data_i  (rx_data_i),
    .pop_i   (data_rd && !loop_on),
    .head_o  (fifo_head),
    .empty_o (fifo_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      lb_buf_q  <= '0;
      lb_full_q <= 1'b0;
    end else begin
      if (wr_en_i && sel_i == REG_CTRL) ctrl_q <= wdata_i;
      if (data_wr && loop_on) begin
        lb_buf_q  <= wdata_i;
        lb_full_q <= 1'b1;
      end else if (data_rd && loop_on) begin
        lb_full_q <= 1'b0;
      end
    end
  end

  assign rbne  = loop_on ? lb_full_q : !fifo_empty;
  assign irq_o = rbne;

  always_comb begin
    status          = '0;
    status[ST_RBNE] = rbne;
    status[ST_CMP]  = irq_any_i;
    status[ST_DSHD] = !(ctrl_q[CTL_DIAG] && !ctrl_q[CTL_DDIR]);
    status[ST_CSHD] = !(ctrl_q[CTL_DIAG] && !ctrl_q[CTL_CDIR]);
  end

  always_comb begin
    unique case (sel_i)
      REG_ID:   rdata_o = DW'(PORT_ID);
      REG_DATA: rdata_o = loop_on ? lb_buf_q : (fifo_empty ? '0 : fifo_head);
      REG_CTRL: rdata_o = ctrl_q;
      default:  rdata_o = status;
    endcase
  end
endmodule

// File: rtl/ps2_dual_regif.sv
module ps2_dual_regif
  import ps2_regif_pkg::*;
#(
  parameter int WIN_BITS = 8,
  parameter int DEPTH    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [WIN_BITS:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o,
  output logic [1:0]        tx_valid_o,
  output logic [2*DW-1:0]   tx_data_o,
  input  logic [1:0]        rx_valid_i,
  input  logic [2*DW-1:0]   rx_data_i,
  output logic              irq_o
);
  localparam int NPORT = 2;

  logic              port_sel;
  reg_sel_e          reg_sel;
  logic [NPORT-1:0]  port_irq;
  logic [DW-1:0]     port_rdata [NPORT];
  logic [DW-1:0]     rdata_q;
  logic              rvalid_q;

  assign port_sel = addr_i[WIN_BITS];
  assign reg_sel  = reg_sel_e'(addr_i[3:2]);
  assign irq_o    = |port_irq;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    ps2_host_port #(.PORT_ID(g), .DEPTH(DEPTH)) u_port (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (req_i && we_i && (port_sel == g[0])),
      .rd_en_i    (req_i && !we_i && (port_sel == g[0])),
      .sel_i      (reg_sel),
      .wdata_i    (wdata_i),
      .rx_valid_i (rx_valid_i[g]),
      .rx_data_i  (rx_data_i[g*DW +: DW]),
      .irq_any_i  (irq_o),
      .rdata_o    (port_rdata[g]),
      .tx_valid_o (tx_valid_o[g]),
      .tx_data_o  (tx_data_o[g*DW +: DW]),
      .irq_o      (port_irq[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= req_i && !we_i;
      if (req_i && !we_i) rdata_q <= port_rdata[port_sel];
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/ps2_dual_regif_chk.sv
module ps2_dual_regif_chk #(
  parameter int WIN_BITS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [WIN_BITS:0] addr_i,
  input logic [7:0]        rdata_o,
  input logic              rvalid_o,
  input logic [1:0]        tx_valid_o,
  input logic              irq_o
);
  logic rd_req;
  assign rd_req = req_i && !we_i;

  p_rvalid_after_read_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rvalid_o);

  p_no_spurious_rvalid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rvalid_o);

  p_id_value_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && addr_i[3:2] == 2'd0) |=> (rdata_o == {7'b0, $past(addr_i[WIN_BITS])}));

  p_tx_only_on_data_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tx_valid_o) |-> (req_i && we_i && addr_i[3:2] == 2'd1));

  p_tx_one_port_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tx_valid_o));

  p_status_zero_bits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && addr_i[3:2] == 2'd3) |=> (rdata_o[3:1] == 3'b000 && !rdata_o[5]));

  p_status_cmp_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && addr_i[3:2] == 2'd3) |=> (rdata_o[4] == $past(irq_o)));
endmodule

bind ps2_dual_regif ps2_dual_regif_chk #(.WIN_BITS(WIN_BITS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .rvalid_o   (rvalid_o),
  .tx_valid_o (tx_valid_o),
  .irq_o      (irq_o)
);

// File: tb/ps2_dual_regif_bench.sv
`timescale 1ns/1ps
module ps2_dual_regif_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [8:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        rvalid_o;
  logic [1:0]  tx_valid_o;
  logic [15:0] tx_data_o;
  logic [1:0]  rx_valid_i = '0;
  logic [15:0] rx_data_i = '0;
  logic        irq_o;

  int vectors = 0, errors = 0, cycles = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  ps2_dual_regif u_ps2_dual_regif (.*);

  always #2 clk_i = ~clk_i;

  function automatic [8:0] adr(input bit p, input [1:0] r);
    adr = {p, 4'h0, r, 2'b00};
  endfunction

  function automatic [7:0] st(input bit rbne, input bit cmp, input [7:0] c);
    st = {~(c[5] & ~c[7]), ~(c[5] & ~c[6]), 1'b0, cmp, 3'b000, rbne};
  endfunction

  task automatic check(input string tag, input [7:0] act, input [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && rvalid_o) begin
      if (exp_q.size() == 0) begin
        vectors++; errors++;
        $display("FAIL R1: actual unexpected rvalid %02h expected none", rdata_o);
      end else begin
        check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input bit p, input [1:0] r, input [7:0] d);
    req_i = 1; we_i = 1; addr_i = adr(p, r); wdata_i = d;
    @(posedge clk_i); #1;
    req_i = 0; we_i = 0;
  endtask

  task automatic rd_a(input [8:0] a, input [7:0] exp, input string tag);
    req_i = 1; we_i = 0; addr_i = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk_i); #1;
    req_i = 0;
  endtask

  task automatic rd(input bit p, input [1:0] r, input [7:0] exp, input string tag);
    rd_a(adr(p, r), exp, tag);
  endtask

  task automatic push(input bit p, input [7:0] d);
    rx_valid_i[p] = 1; rx_data_i[p*8 +: 8] = d;
    @(posedge clk_i); #1;
    rx_valid_i = '0;
  endtask

  // transmit write with same-cycle strobe check
  task automatic wr_tx(input bit p, input [7:0] d, input [1:0] exp_v, input string tag);
    req_i = 1; we_i = 1; addr_i = adr(p, 2'd1); wdata_i = d;
    #1;
    check({tag, " strobe"}, {6'b0, tx_valid_o}, {6'b0, exp_v});
    if (exp_v != 0) check({tag, " byte"}, tx_data_o[p*8 +: 8], d);
    @(posedge clk_i); #1;
    req_i = 0; we_i = 0;
  endtask

  task automatic drain();
    repeat (3) @(posedge clk_i);
    #1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      vectors++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    @(posedge clk_i); #1;

    // reset state, R3 R8
    rd(0, 2, 8'h00, "R3 reset ctrl");
    rd(0, 3, 8'hC0, "R8 reset kbd status");
    rd(1, 3, 8'hC0, "R8 reset mouse status");
    check("R10 reset irq", {7'b0, irq_o}, 8'h00);

    // identity and decode, R2 R1
    rd(0, 0, 8'h00, "R2 kbd id");
    rd(1, 0, 8'h01, "R2 mouse id");
    rd_a(9'h1F0, 8'h01, "R1 aliased mouse id");
    rd_a(9'h0E8, 8'h00, "R1 aliased kbd ctrl");

    // control storage, R3
    wr(0, 2, 8'hA5);
    wr(1, 2, 8'h3C);
    wr(0, 0, 8'hFF);
    rd(0, 2, 8'hA5, "R3 kbd ctrl after reset-reg write");
    rd(1, 2, 8'h3C, "R3 mouse ctrl independent");

    // diagnostic shadows, R9
    wr(1, 2, 8'h20); rd(1, 3, st(0, 0, 8'h20), "R9 diag no dirs");
    wr(1, 2, 8'h60); rd(1, 3, st(0, 0, 8'h60), "R9 diag data dir");
    wr(1, 2, 8'hA0); rd(1, 3, st(0, 0, 8'hA0), "R9 diag clk dir");
    wr(1, 2, 8'hC0); rd(1, 3, 8'hC0, "R9 dirs without diag");

    // normal transmit, R4
    wr(0, 2, 8'h01);
    wr(1, 2, 8'h01);
    wr_tx(0, 8'h5A, 2'b01, "R4 kbd tx");
    wr_tx(1, 8'hC3, 2'b10, "R4 mouse tx");

    // loopback, R5 R10
    wr(1, 2, 8'h03);
    wr_tx(1, 8'h77, 2'b00, "R5 loopback no strobe");
    check("R10 loopback irq", {7'b0, irq_o}, 8'h01);
    rd(1, 3, st(1, 1, 8'h03), "R5 loopback status");
    rd(0, 3, st(0, 1, 8'h01), "R10 cmp seen by kbd");
    rd(1, 1, 8'h77, "R5 loopback data");
    drain();
    check("R5 irq cleared", {7'b0, irq_o}, 8'h00);
    rd(1, 3, st(0, 0, 8'h03), "R5 status cleared");

    // FIFO order and empty read, R6 R7
    push(0, 8'h11); push(0, 8'h22); push(0, 8'h33);
    check("R10 fifo irq", {7'b0, irq_o}, 8'h01);
    rd(0, 3, st(1, 1, 8'h01), "R10 fifo status");
    rd(0, 1, 8'h11, "R6 pop 1");
    rd(0, 1, 8'h22, "R6 pop 2");
    rd(0, 1, 8'h33, "R6 pop 3");
    rd(0, 1, 8'h00, "R7 empty read");
    rd(0, 3, st(0, 0, 8'h01), "R7 status after empty read");

    // overflow, R6
    for (int i = 0; i < 18; i++) push(0, 8'h40 + 8'(i));
    for (int i = 0; i < 16; i++) rd(0, 1, 8'h40 + 8'(i), "R6 overflow order");
    rd(0, 1, 8'h00, "R6 extra bytes dropped");

    // push and pop together, R11
    rx_valid_i[0] = 1; rx_data_i[7:0] = 8'h99;
    req_i = 1; we_i = 0; addr_i = adr(0, 1);
    exp_q.push_back(8'h00); tag_q.push_back("R11 empty collide read");
    @(posedge clk_i); #1;
    req_i = 0; rx_valid_i = '0;
    rd(0, 1, 8'h99, "R11 empty collide kept");
    for (int i = 0; i < 16; i++) push(0, 8'h60 + 8'(i));
    rx_valid_i[0] = 1; rx_data_i[7:0] = 8'hAA;
    req_i = 1; we_i = 0; addr_i = adr(0, 1);
    exp_q.push_back(8'h60); tag_q.push_back("R11 full collide read");
    @(posedge clk_i); #1;
    req_i = 0; rx_valid_i = '0;
    for (int i = 1; i < 16; i++) rd(0, 1, 8'h60 + 8'(i), "R11 full collide order");
    rd(0, 1, 8'hAA, "R11 full collide kept");
    rd(0, 1, 8'h00, "R11 drained");

    // mouse fifo drives combined irq, R10
    wr(1, 2, 8'h00);
    push(1, 8'h5C);
    rd(0, 3, st(0, 1, 8'h01), "R10 kbd sees mouse irq");
    rd(1, 3, st(1, 1, 8'h00), "R10 mouse rbne");
    drain();

    // reset mid-run, R3
    push(0, 8'h12);
    rst_ni = 0;
    @(posedge clk_i); #1;
    rst_ni = 1;
    @(posedge clk_i); #1;
    check("R10 irq after reset", {7'b0, irq_o}, 8'h00);
    rd(0, 2, 8'h00, "R3 ctrl after reset");
    rd(1, 3, 8'hC0, "R6 mouse fifo cleared");
    rd(0, 1, 8'h00, "R6 kbd fifo cleared");
    drain();

    if (exp_q.size() != 0) check("R1 missing responses", 8'(exp_q.size()), 8'h00);
    summary();
  end
endmodule